// File: doc/BRIEF.md
# CAN Transmit Object Selector

This block decides which of a set of CAN message objects goes on the bus next. Each object holds an arbitration word and a small set of control flags:
- The arbitration word carries the identifier, the frame-format flag and a two-bit selection class.
- The control flags are a direction flag, a valid flag and two transmit-enable flags.

A register-file write port loads one whole object per cycle. The block looks at every object at once and reports the winner on three registered outputs: a one-hot grant vector, the winner's index, and a found flag.

An object's selection class sets its rule. Under the list rule, an object may win only when no object earlier in the list is requesting. Under the identifier rule, an object may win only when no other requesting object ranks ahead of it under CAN bus arbitration. That ranking takes in the identifier, the frame format and the frame type (data or remote). One class value is held back for time-triggered use, and objects in that class never win.

Top module: `cantx_sel`

## Requirements
- R1: After reset every object reads as all-zero. `grant_oh` is all-zero, `grant_found` is 0 and `grant_idx` is 0.
- R2: An object requests only when its valid flag and both transmit-enable flags are all 1. An object that lacks any one of them is never granted.
- R3: An object whose class field is 00 is never granted, even when it is requesting.
- R4: Class 01 selects by list order. A requesting object may win only if no object with a lower index is requesting, whatever that object's class.
- R5: Class 11 behaves exactly like class 01.
- R6: Class 10 selects by identifier. A requesting object may win only if no other requesting object ranks ahead of it. A numerically lower arbitration value ranks ahead.
- R7: A standard identifier sits in identifier bits 28:18. Its 11 bits are ranked against bits 28:18 of an extended identifier, and the lower base wins.
- R8: When two objects share the same 11-bit base, ranking follows the CAN arbitration bit order:
  - A standard data frame ranks ahead of a standard remote frame.
  - A standard remote frame ranks ahead of any extended frame.
  - Between two extended frames with the same full identifier, a data frame ranks ahead of a remote frame.
  - Direction flag 1 means a data frame and 0 means a remote frame.
- R9: An exact tie under identifier ranking goes to the lower index. At most one grant bit is ever set.
  - If several objects qualify under their own rules, the lowest qualifying index wins.
- R10: Outputs are registered. Object state written on clock edge t affects the outputs from edge t+1 onward. `grant_found` is 0 and `grant_oh` is zero when no object qualifies.
- R11: A write with `wr_en` high loads object `wr_idx` in one edge. The layout of `wr_arb` is identifier in 28:0, extended flag in 29 and class in 31:30. The layout of `wr_flags` is direction in bit 3, valid in bit 2, transmit-enable B in bit 1 and transmit-enable A in bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Object write strobe |
| wr_idx | input | IDX_W | Index of the object to load |
| wr_arb | input | 32 | Arbitration word: class, extended flag, identifier |
| wr_flags | input | 4 | Direction, valid, transmit-enable B, transmit-enable A |
| grant_oh | output | NUM_OBJ | One-hot grant vector |
| grant_idx | output | IDX_W | Index of the granted object |
| grant_found | output | 1 | High when an object is granted |

## Verification
The assertions assume that `wr_idx` stays below `NUM_OBJ` whenever `wr_en` is high. They also assume that the outputs in any cycle depend only on object state from the cycle before. The stimulus writes only indices inside the list and changes inputs only on falling edges. It also waits one full cycle after each write before it compares the outputs. Some runs mix classes in one list on purpose, to cover the case where a class-00 object blocks a later list-order object.

// File: rtl/cantx_pkg.sv
package cantx_pkg;

    typedef enum logic [1:0] {
        CLS_TIMED = 2'b00,
        CLS_LIST  = 2'b01,
        CLS_IDENT = 2'b10,
        CLS_LIST2 = 2'b11
    } sel_class_e;

    typedef struct packed {
        logic [1:0]  cls;
        logic        ext;
        logic [28:0] ident;
        logic        dir;
        logic        valid;
        logic        txen_b;
        logic        txen_a;
    } tx_obj_t;

    localparam int KEY_W = 32;

    // Bus-order arbitration value: a lower value wins on the wire.
    // Standard: base, RTR, IDE=0. Extended: base, SRR=1, IDE=1, ext bits, RTR.
    function automatic logic [KEY_W-1:0] arb_key(tx_obj_t o);
        if (o.ext)
            return {o.ident[28:18], 1'b1, 1'b1, o.ident[17:0], ~o.dir};
        else
            return {o.ident[28:18], ~o.dir, 1'b0, 18'd0, 1'b0};
    endfunction

    function automatic logic is_req(tx_obj_t o);
        return o.valid & o.txen_a & o.txen_b;
    endfunction

endpackage

// File: rtl/cantx_objfile.sv
module cantx_objfile
    import cantx_pkg::*;
#(
    parameter int NUM_OBJ = 8,
    localparam int IDX_W = (NUM_OBJ > 1) ? $clog2(NUM_OBJ) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [31:0]      wr_arb,
    input  logic [3:0]       wr_flags,
    output tx_obj_t          objs [NUM_OBJ]
);
    tx_obj_t wr_obj;

    always_comb begin
        wr_obj.cls    = wr_arb[31:30];
        wr_obj.ext    = wr_arb[29];
        wr_obj.ident  = wr_arb[28:0];
        wr_obj.dir    = wr_flags[3];
        wr_obj.valid  = wr_flags[2];
        wr_obj.txen_b = wr_flags[1];
        wr_obj.txen_a = wr_flags[0];
    end

    for (genvar g = 0; g < NUM_OBJ; g++) begin : g_obj
        always_ff @(posedge clk) begin
            if (rst)
                objs[g] <= '0;
            else if (wr_en && (wr_idx == IDX_W'(g)))
                objs[g] <= wr_obj;
        end
    end

    p_wr_range_r11: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (int'(wr_idx) < NUM_OBJ));
endmodule

// File: rtl/cantx_pick.sv
module cantx_pick
    import cantx_pkg::*;
#(
    parameter int NUM_OBJ = 8,
    localparam int IDX_W = (NUM_OBJ > 1) ? $clog2(NUM_OBJ) : 1
) (
    input  tx_obj_t            objs [NUM_OBJ],
    output logic [NUM_OBJ-1:0] req_vec,
    output logic [NUM_OBJ-1:0] sel_oh,
    output logic [IDX_W-1:0]   sel_idx,
    output logic               sel_found
);
    logic [KEY_W-1:0]   keys [NUM_OBJ];
    logic [NUM_OBJ-1:0] cand;

    for (genvar g = 0; g < NUM_OBJ; g++) begin : g_key
        assign keys[g]    = arb_key(objs[g]);
        assign req_vec[g] = is_req(objs[g]);
    end

    // Per-object qualification under its own class rule.
    always_comb begin
        for (int i = 0; i < NUM_OBJ; i++) begin
            logic blocked;
            blocked = 1'b0;
            unique case (sel_class_e'(objs[i].cls))
                CLS_LIST, CLS_LIST2: begin
                    for (int j = 0; j < NUM_OBJ; j++)
                        if (j < i && req_vec[j]) blocked = 1'b1;
                end
                CLS_IDENT: begin
                    for (int j = 0; j < NUM_OBJ; j++)
                        if (j != i && req_vec[j] &&
                            ((keys[j] < keys[i]) || (keys[j] == keys[i] && j < i)))
                            blocked = 1'b1;
                end
                default: blocked = 1'b1;
            endcase
            cand[i] = req_vec[i] & ~blocked;
        end
    end

    // Lowest qualifying index wins when rules of mixed classes overlap.
    always_comb begin
        sel_found = 1'b0;
        sel_idx   = '0;
        for (int i = 0; i < NUM_OBJ; i++) begin
            if (cand[i] && !sel_found) begin
                sel_found = 1'b1;
                sel_idx   = IDX_W'(i);
            end
        end
        sel_oh = sel_found ? (NUM_OBJ'(1) << sel_idx) : '0;
    end
endmodule

// File: rtl/cantx_sel.sv
module cantx_sel
    import cantx_pkg::*;
#(
    parameter int NUM_OBJ = 8,
    localparam int IDX_W = (NUM_OBJ > 1) ? $clog2(NUM_OBJ) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [31:0]        wr_arb,
    input  logic [3:0]         wr_flags,
    output logic [NUM_OBJ-1:0] grant_oh,
    output logic [IDX_W-1:0]   grant_idx,
    output logic               grant_found
);
    tx_obj_t            objs [NUM_OBJ];
    logic [NUM_OBJ-1:0] req_vec;
    logic [NUM_OBJ-1:0] sel_oh;
    logic [IDX_W-1:0]   sel_idx;
    logic               sel_found;
    logic [NUM_OBJ-1:0] cls_zero;

    cantx_objfile #(.NUM_OBJ(NUM_OBJ)) u_file (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_arb(wr_arb), .wr_flags(wr_flags), .objs(objs)
    );

    cantx_pick #(.NUM_OBJ(NUM_OBJ)) u_pick (
        .objs(objs), .req_vec(req_vec), .sel_oh(sel_oh),
        .sel_idx(sel_idx), .sel_found(sel_found)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            grant_oh    <= '0;
            grant_idx   <= '0;
            grant_found <= 1'b0;
        end else begin
            grant_oh    <= sel_oh;
            grant_idx   <= sel_idx;
            grant_found <= sel_found;
        end
    end

    for (genvar g = 0; g < NUM_OBJ; g++) begin : g_cls
        assign cls_zero[g] = (objs[g].cls == CLS_TIMED);
    end

    p_onehot_r9: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant_oh));
    p_found_match_r10: assert property (@(posedge clk) disable iff (rst)
        grant_found == (grant_oh != '0));
    p_idx_match_r9: assert property (@(posedge clk) disable iff (rst)
        grant_found |-> (grant_oh == (NUM_OBJ'(1) << grant_idx)));
    p_grant_req_r2: assert property (@(posedge clk) disable iff (rst)
        grant_found |-> (($past(req_vec) & grant_oh) != '0));
    p_no_timed_r3: assert property (@(posedge clk) disable iff (rst)
        grant_found |-> (($past(cls_zero) & grant_oh) == '0));
endmodule

// File: tb/cantx_sel_tb.sv
module cantx_sel_tb_top;
    localparam int N = 8;
    localparam int IW = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [IW-1:0] wr_idx = '0;
    logic [31:0]   wr_arb = '0;
    logic [3:0]    wr_flags = '0;
    logic [N-1:0]  grant_oh;
    logic [IW-1:0] grant_idx;
    logic          grant_found;

    always #10 clk = ~clk;

    cantx_sel #(.NUM_OBJ(N)) dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_arb(wr_arb), .wr_flags(wr_flags), .grant_oh(grant_oh),
        .grant_idx(grant_idx), .grant_found(grant_found)
    );

    typedef struct {
        logic  found;
        int    idx;
        string tag;
    } exp_t;

    exp_t        sbq[$];
    int          checks = 0;
    int          fails = 0;
    logic [31:0] sh_arb [N];
    logic [3:0]  sh_flg [N];
    bit          done = 0;

    function automatic logic m_req(int i);
        return sh_flg[i][2] & sh_flg[i][1] & sh_flg[i][0];
    endfunction

    // -1: a ahead of b, 1: b ahead of a, 0: exact tie
    function automatic int m_rank(int a, int b);
        logic [10:0] ba = sh_arb[a][28:18];
        logic [10:0] bb = sh_arb[b][28:18];
        int ca, cb;
        if (ba != bb) return (ba < bb) ? -1 : 1;
        ca = sh_arb[a][29] ? 2 : (sh_flg[a][3] ? 0 : 1);
        cb = sh_arb[b][29] ? 2 : (sh_flg[b][3] ? 0 : 1);
        if (ca != cb) return (ca < cb) ? -1 : 1;
        if (ca != 2) return 0;
        if (sh_arb[a][17:0] != sh_arb[b][17:0])
            return (sh_arb[a][17:0] < sh_arb[b][17:0]) ? -1 : 1;
        if (sh_flg[a][3] != sh_flg[b][3]) return sh_flg[a][3] ? -1 : 1;
        return 0;
    endfunction

    function automatic exp_t model(string tag);
        exp_t e;
        e.found = 1'b0; e.idx = 0; e.tag = tag;
        for (int i = 0; i < N; i++) begin
            bit ok;
            ok = m_req(i);
            if (sh_arb[i][31:30] == 2'b00) ok = 0;
            else if (sh_arb[i][31:30] == 2'b10) begin
                for (int j = 0; j < N; j++)
                    if (j != i && m_req(j) &&
                        (m_rank(j, i) < 0 || (m_rank(j, i) == 0 && j < i))) ok = 0;
            end else begin
                for (int j = 0; j < i; j++) if (m_req(j)) ok = 0;
            end
            if (ok && !e.found) begin e.found = 1'b1; e.idx = i; end
        end
        return e;
    endfunction

    task automatic compare(exp_t e);
        logic [N-1:0] eoh;
        eoh = e.found ? (N'(1) << e.idx) : '0;
        checks++;
        if (grant_found !== e.found || grant_oh !== eoh ||
            (e.found && grant_idx !== IW'(e.idx))) begin
            fails++;
            $display("FAIL %s: found=%0b idx=%0d oh=%b expected found=%0b idx=%0d oh=%b",
                     e.tag, grant_found, grant_idx, grant_oh, e.found, e.idx, eoh);
        end
    endtask

    // Monitor: pops expected items and compares away from the active edge.
    always @(negedge clk) begin
        if (sbq.size() > 0) compare(sbq.pop_front());
    end

    task automatic wr_obj(input int idx, input logic [1:0] cls, input logic ext,
                          input logic [28:0] id, input logic dir, input logic v,
                          input logic ta, input logic tb);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = IW'(idx);
        wr_arb = {cls, ext, id}; wr_flags = {dir, v, tb, ta};
        @(negedge clk);
        wr_en = 1'b0;
        sh_arb[idx] = {cls, ext, id};
        sh_flg[idx] = {dir, v, tb, ta};
    endtask

    task automatic expect_sel(string tag);
        @(posedge clk); #1;
        sbq.push_back(model(tag));
        @(negedge clk);
    endtask

    task automatic clear_all();
        for (int i = 0; i < N; i++) wr_obj(i, 2'b00, 1'b0, 29'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    function automatic logic [28:0] std_id(logic [10:0] b);
        return {b, 18'd0};
    endfunction

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : driver
        exp_t e;
        for (int i = 0; i < N; i++) begin sh_arb[i] = '0; sh_flg[i] = '0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        e = model("R1 reset state"); compare(e);
        rst = 1'b0;
        @(negedge clk);

        // R4 / R11: list order, lower index wins
        wr_obj(5, 2'b01, 1'b0, std_id(11'h010), 1'b1, 1, 1, 1);
        // R10: just after the write edge the output still shows the old state
        e = model("R10 latency before update"); e.found = 1'b0; compare(e);
        expect_sel("R10 one cycle after write");
        wr_obj(2, 2'b01, 1'b0, std_id(11'h7F0), 1'b1, 1, 1, 1);
        expect_sel("R4 list order picks index 2");

        // R2: each missing flag removes the request
        wr_obj(2, 2'b01, 1'b0, std_id(11'h7F0), 1'b1, 1, 0, 1);
        expect_sel("R2 txen A low");
        wr_obj(2, 2'b01, 1'b0, std_id(11'h7F0), 1'b1, 1, 1, 0);
        expect_sel("R2 txen B low");
        wr_obj(2, 2'b01, 1'b0, std_id(11'h7F0), 1'b1, 0, 1, 1);
        expect_sel("R2 valid low");
        wr_obj(5, 2'b01, 1'b0, std_id(11'h010), 1'b1, 0, 1, 1);
        expect_sel("R10 none eligible");

        // R5: class 11 is list order
        wr_obj(4, 2'b11, 1'b0, std_id(11'h001), 1'b1, 1, 1, 1);
        wr_obj(1, 2'b11, 1'b0, std_id(11'h7FF), 1'b1, 1, 1, 1);
        expect_sel("R5 class 11 list order");
        wr_obj(1, 2'b01, 1'b0, std_id(11'h7FF), 1'b1, 1, 1, 1);
        expect_sel("R5 class 11 behind class 01");
        clear_all();

        // R3: class 00 never granted, yet it still blocks later list objects
        wr_obj(3, 2'b00, 1'b0, std_id(11'h000), 1'b1, 1, 1, 1);
        expect_sel("R3 class 00 alone");
        wr_obj(6, 2'b01, 1'b0, std_id(11'h000), 1'b1, 1, 1, 1);
        expect_sel("R3 class 00 blocks later list object");
        wr_obj(3, 2'b00, 1'b0, std_id(11'h000), 1'b1, 0, 1, 1);
        expect_sel("R3 list object after class 00 dropped");
        clear_all();

        // R6: lowest identifier wins
        wr_obj(0, 2'b10, 1'b1, 29'h0000_1000, 1'b1, 1, 1, 1);
        wr_obj(1, 2'b10, 1'b1, 29'h0000_0800, 1'b1, 1, 1, 1);
        wr_obj(2, 2'b10, 1'b1, 29'h0000_2000, 1'b1, 1, 1, 1);
        expect_sel("R6 lowest extended identifier");
        wr_obj(7, 2'b10, 1'b1, 29'h0000_0001, 1'b1, 1, 1, 1);
        expect_sel("R6 high index lower identifier");
        clear_all();

        // R7: standard base compared with extended bits 28:18
        wr_obj(0, 2'b10, 1'b0, std_id(11'h100), 1'b1, 1, 1, 1);
        wr_obj(1, 2'b10, 1'b1, {11'h0FF, 18'h3FFFF}, 1'b1, 1, 1, 1);
        expect_sel("R7 extended with lower base wins");
        wr_obj(1, 2'b10, 1'b1, {11'h101, 18'h00000}, 1'b1, 1, 1, 1);
        expect_sel("R7 standard with lower base wins");
        clear_all();

        // R8: equal base ordering
        wr_obj(0, 2'b10, 1'b1, {11'h155, 18'h00000}, 1'b1, 1, 1, 1);
        wr_obj(1, 2'b10, 1'b0, std_id(11'h155), 1'b0, 1, 1, 1);
        wr_obj(2, 2'b10, 1'b0, std_id(11'h155), 1'b1, 1, 1, 1);
        expect_sel("R8 standard data first");
        wr_obj(2, 2'b10, 1'b0, std_id(11'h155), 1'b1, 0, 1, 1);
        expect_sel("R8 standard remote beats extended");
        wr_obj(1, 2'b10, 1'b0, std_id(11'h155), 1'b0, 0, 1, 1);
        expect_sel("R8 extended remaining");
        wr_obj(0, 2'b10, 1'b1, {11'h155, 18'h00042}, 1'b0, 1, 1, 1);
        wr_obj(3, 2'b10, 1'b1, {11'h155, 18'h00042}, 1'b1, 1, 1, 1);
        expect_sel("R8 extended data beats extended remote");
        clear_all();

        // R9: exact tie to lower index
        wr_obj(6, 2'b10, 1'b0, std_id(11'h222), 1'b1, 1, 1, 1);
        wr_obj(4, 2'b10, 1'b0, std_id(11'h222), 1'b1, 1, 1, 1);
        expect_sel("R9 tie goes to lower index");
        clear_all();
        expect_sel("R10 cleared list");

        while (sbq.size() > 0) @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule